// File: doc/BRIEF.md
# External I/O Bank Wait-State Controller

This block sits between a CPU's I/O request interface and the pins of an external I/O bus. It splits the 64K I/O address space into eight equal banks by the top three address bits. Each bank has its own 8-bit control register. That register sets how many wait states an external access to the bank takes, whether writes to the bank are blocked, and what shape of strobe the bank drives on its own port pin.

An access starts with a one-clock read or write request while the block is idle. External accesses last two clocks plus the bank's wait count. The global active-low read and write strobes are low from the second clock to the last clock. A one-clock done pulse marks the last clock. Internal I/O accesses take two clocks, use no bank register and drive no strobe.

A bank's pin carries its strobe only when both the port direction bit and the port function bit for that pin are set. A bank's wait count applies whether or not its pin is enabled.

Top module: `ioBankWait`

## Requirements
- R1: After reset the block is idle: busy and done are 0 and ioRdN, ioWrN and all of bankStbN are 1. Every control register is cleared, so each bank starts with 15 wait states and a chip-select strobe.
- R2: ioAddr[15:13] selects the bank, and bank n drives only bankStbN[n]. At most one bank pin is low at any time.
- R3: Control register bits 7:6 set the wait count W: 00=15, 01=7, 10=3, 11=1. An external access keeps busy high for exactly 2+W clocks, and done is high only on the last of them.
- R4: In an external read, ioRdN is low from the second clock through the last clock, and ioWrN stays high. A write behaves the same way on ioWrN.
- R5: The wait count of the addressed bank sets the cycle length even when that bank's pin is disabled or its strobe is suppressed.
- R6: Control bit 5 (write inhibit) keeps ioWrN and the bank pin high for writes to that bank. The cycle length is unchanged, and reads are not affected.
- R7: Control bits 4:3 select the pin strobe. 00 is a chip select, low on every clock of a read or write. 01 is low only for reads, 10 only for writes, and 11 for both. Types 01, 10 and 11 are low from the second clock through the last clock.
- R8: bankStbN[n] can go low only when portDir[n] and portFunc[n] are both 1.
- R9: An internal access (isInternal=1) takes exactly 2 clocks whatever the bank registers hold. It keeps ioRdN, ioWrN and all bank pins high.
- R10: A control register write made during an access does not change that access. It applies from the next access.
- R11: A read or write request that arrives while the block is busy is ignored. It does not lengthen or restart the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address, sampled when a request is accepted |
| isInternal | input | 1 | 1 marks an internal I/O access |
| rdReq | input | 1 | Read request, accepted when idle |
| wrReq | input | 1 | Write request, accepted when idle (a read wins if both are high) |
| cfgWe | input | 1 | Control register write enable |
| cfgSel | input | 3 | Index of the control register to write |
| cfgData | input | 8 | Control register write data |
| portDir | input | 8 | Port direction bits, 1 = output |
| portFunc | input | 8 | Port function bits, 1 = bank strobe |
| ioRdN | output | 1 | Global active-low read strobe |
| ioWrN | output | 1 | Global active-low write strobe |
| bankStbN | output | 8 | Active-low per-bank strobe pins |
| busy | output | 1 | High during every clock of an access |
| done | output | 1 | One-clock pulse on the last clock of an access |

## Verification
All four wait encodings are run through one bank. Comparing the busy length, the done position and the first low clock of ioRdN separates the encodings from each other and from the fixed 2-clock internal path. Writes and reads go to every bank, and each of the four strobe types is tried with both directions. Each pin-enable combination and write inhibit is tried with the pin strobe and the global strobes observed. This shows that suppressing a strobe never changes the cycle length. Two mid-access events check the snapshot behaviour: a register rewrite and a second request. The bench compares the length of the current access with the length of the next one.

// File: rtl/ioBankPkg.sv
package ioBankPkg;

  localparam int WAIT_HI  = 7;
  localparam int WAIT_LO  = 6;
  localparam int INH_BIT  = 5;
  localparam int KIND_HI  = 4;
  localparam int KIND_LO  = 3;
  localparam int WAIT_W   = 5;

  typedef enum logic [1:0] {
    STB_CS = 2'b00,
    STB_RD = 2'b01,
    STB_WR = 2'b10,
    STB_RW = 2'b11
  } stbKind_t;

  typedef struct packed {
    logic load;
    logic active;
    logic first;
    logic last;
    logic ext;
    logic write;
  } ctlStrb_t;

  function automatic logic [WAIT_W-1:0] waitsOf(input logic [1:0] field);
    case (field)
      2'b00:   waitsOf = 5'd15;
      2'b01:   waitsOf = 5'd7;
      2'b10:   waitsOf = 5'd3;
      default: waitsOf = 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/cycleCtrl.sv
module cycleCtrl
  import ioBankPkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int INT_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic             wrReq,
  input  logic             isInternal,
  input  logic [CNT_W-1:0] extWaits,
  output ctlStrb_t         strb,
  output logic             busy,
  output logic             done
);

  logic             active;
  logic             first;
  logic             extCyc;
  logic             wrCyc;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             lastClk;

  assign accept  = !active && (rdReq || wrReq);
  assign lastClk = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      first  <= 1'b0;
      extCyc <= 1'b0;
      wrCyc  <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      first  <= 1'b1;
      extCyc <= !isInternal;
      wrCyc  <= !rdReq;
      cnt    <= isInternal ? CNT_W'(INT_CYCLES - 1) : extWaits + CNT_W'(1);
    end else if (active) begin
      first <= 1'b0;
      if (cnt == '0) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.active = active;
    strb.first  = first;
    strb.last   = lastClk;
    strb.ext    = extCyc;
    strb.write  = wrCyc;
  end

  assign busy = active;
  assign done = lastClk;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one clock"); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy) else $error("busy after done"); // R3
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && (rdReq || wrReq)) |=> (busy && $stable(wrCyc) && $stable(extCyc)))
    else $error("request accepted while busy"); // R11

endmodule

// File: rtl/bankDatapath.sv
module bankDatapath
  import ioBankPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 3,
  parameter int CFG_W     = 8,
  parameter int CNT_W     = 5,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    ioAddr,
  input  logic                 cfgWe,
  input  logic [BANK_BITS-1:0] cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [NUM_BANKS-1:0] portDir,
  input  logic [NUM_BANKS-1:0] portFunc,
  input  ctlStrb_t             strb,
  output logic [CNT_W-1:0]     extWaits,
  output logic                 ioRdN,
  output logic                 ioWrN,
  output logic [NUM_BANKS-1:0] bankStbN
);

  logic [CFG_W-1:0]     cfgRegs [NUM_BANKS];
  logic [BANK_BITS-1:0] reqBank;
  logic [BANK_BITS-1:0] curBank;
  logic [CFG_W-1:0]     curCfg;
  logic                 curInh;
  stbKind_t             curKind;
  logic                 extOn;
  logic                 lateOn;
  logic                 kindOn;

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : gRegs
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfgRegs[g] <= '0;
        end else if (cfgWe && (cfgSel == BANK_BITS'(g))) begin
          cfgRegs[g] <= cfgData;
        end
      end
    end
  endgenerate

  assign reqBank  = ioAddr[ADDR_W-1 -: BANK_BITS];
  assign extWaits = CNT_W'(waitsOf(cfgRegs[reqBank][WAIT_HI:WAIT_LO]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank <= '0;
      curCfg  <= '0;
    end else if (strb.load) begin
      curBank <= reqBank;
      curCfg  <= cfgRegs[reqBank];
    end
  end

  assign curInh  = curCfg[INH_BIT];
  assign curKind = stbKind_t'(curCfg[KIND_HI:KIND_LO]);
  assign extOn   = strb.active && strb.ext;
  assign lateOn  = extOn && !strb.first;

  assign ioRdN = !(lateOn && !strb.write);
  assign ioWrN = !(lateOn && strb.write && !curInh);

  always_comb begin
    case (curKind)
      STB_CS:  kindOn = extOn && !(strb.write && curInh);
      STB_RD:  kindOn = lateOn && !strb.write;
      STB_WR:  kindOn = lateOn && strb.write && !curInh;
      default: kindOn = lateOn && !(strb.write && curInh);
    endcase
  end

  generate
    for (g = 0; g < NUM_BANKS; g++) begin : gPins
      assign bankStbN[g] = !(kindOn && (curBank == BANK_BITS'(g)) && portDir[g] && portFunc[g]);

      AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
        !(portDir[g] && portFunc[g]) |-> bankStbN[g]) else $error("pin not gated"); // R8
    end
  endgenerate

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (ioRdN && ioWrN && (&bankStbN))) else $error("strobe while idle"); // R1
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.first |-> (ioRdN && ioWrN)) else $error("global strobe on first clock"); // R4
  AST_PIN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~bankStbN)) else $error("more than one bank pin low"); // R2
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.ext) |-> (ioRdN && ioWrN && (&bankStbN)))
    else $error("strobe on internal access"); // R9
  AST_INHIBIT_WR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.write && curInh) |-> (ioWrN && (&bankStbN)))
    else $error("inhibited write strobed"); // R6

endmodule

// File: rtl/ioBankWait.sv
module ioBankWait
  import ioBankPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_BITS  = 3,
  parameter int CFG_W      = 8,
  parameter int INT_CYCLES = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int CNT_W     = WAIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    ioAddr,
  input  logic                 isInternal,
  input  logic                 rdReq,
  input  logic                 wrReq,
  input  logic                 cfgWe,
  input  logic [BANK_BITS-1:0] cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [NUM_BANKS-1:0] portDir,
  input  logic [NUM_BANKS-1:0] portFunc,
  output logic                 ioRdN,
  output logic                 ioWrN,
  output logic [NUM_BANKS-1:0] bankStbN,
  output logic                 busy,
  output logic                 done
);

  ctlStrb_t         strb;
  logic [CNT_W-1:0] extWaits;

  cycleCtrl #(
    .CNT_W      (CNT_W),
    .INT_CYCLES (INT_CYCLES)
  ) i_cycleCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdReq      (rdReq),
    .wrReq      (wrReq),
    .isInternal (isInternal),
    .extWaits   (extWaits),
    .strb       (strb),
    .busy       (busy),
    .done       (done)
  );

  bankDatapath #(
    .ADDR_W    (ADDR_W),
    .BANK_BITS (BANK_BITS),
    .CFG_W     (CFG_W),
    .CNT_W     (CNT_W)
  ) i_bankDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .portDir  (portDir),
    .portFunc (portFunc),
    .strb     (strb),
    .extWaits (extWaits),
    .ioRdN    (ioRdN),
    .ioWrN    (ioWrN),
    .bankStbN (bankStbN)
  );

endmodule

// File: tb/test_ioBankWait.sv
module test_ioBankWait;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic        isInternal;
  logic        rdReq;
  logic        wrReq;
  logic        cfgWe;
  logic [2:0]  cfgSel;
  logic [7:0]  cfgData;
  logic [7:0]  portDir;
  logic [7:0]  portFunc;
  logic        ioRdN;
  logic        ioWrN;
  logic [7:0]  bankStbN;
  logic        busy;
  logic        done;

  int total = 0;
  int bad   = 0;

  int mLen, mDone, mDoneCnt, mRdLow, mRdFirst, mWrLow, mWrFirst, mStbLow, mStbFirst;
  logic [7:0] mStbMask;

  always #4 clk = ~clk;

  ioBankWait i_ioBankWait (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .isInternal(isInternal),
    .rdReq(rdReq), .wrReq(wrReq), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .portDir(portDir), .portFunc(portFunc),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .bankStbN(bankStbN), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expWaits(input int enc);
    case (enc)
      0:       return 15;
      1:       return 7;
      2:       return 3;
      default: return 1;
    endcase
  endfunction

  task automatic writeCfg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // action: 0 none, 1 extra read request at clock 2, 2 register write at clock 2
  task automatic runAccess(input logic [15:0] a, input bit internal, input bit wr,
                           input int action, input logic [2:0] aSel, input logic [7:0] aData);
    @(negedge clk);
    ioAddr = a; isInternal = internal; rdReq = !wr; wrReq = wr;
    @(negedge clk);
    rdReq = 1'b0; wrReq = 1'b0;
    mLen = 0; mDone = 0; mDoneCnt = 0; mRdLow = 0; mRdFirst = 0;
    mWrLow = 0; mWrFirst = 0; mStbLow = 0; mStbFirst = 0; mStbMask = '0;
    for (int k = 1; k <= 40; k++) begin
      if (!busy) break;
      mLen++;
      if (done) begin mDoneCnt++; mDone = k; end
      if (!ioRdN) begin mRdLow++; if (mRdFirst == 0) mRdFirst = k; end
      if (!ioWrN) begin mWrLow++; if (mWrFirst == 0) mWrFirst = k; end
      if (bankStbN != 8'hFF) begin
        mStbLow++;
        if (mStbFirst == 0) mStbFirst = k;
        mStbMask = mStbMask | ~bankStbN;
      end
      if (k == 2) begin
        if (action == 1) rdReq = 1'b1;
        if (action == 2) begin cfgWe = 1'b1; cfgSel = aSel; cfgData = aData; end
      end
      if (k == 3) begin rdReq = 1'b0; cfgWe = 1'b0; end
      @(negedge clk);
    end
    rdReq = 1'b0; cfgWe = 1'b0;
  endtask

  task automatic tReset;
    rstN = 1'b0; ioAddr = '0; isInternal = 0; rdReq = 0; wrReq = 0;
    cfgWe = 0; cfgSel = '0; cfgData = '0; portDir = 8'hFF; portFunc = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy idle", busy, 0);
    chk("R1", "done idle", done, 0);
    chk("R1", "ioRdN idle", ioRdN, 1);
    chk("R1", "ioWrN idle", ioWrN, 1);
    chk("R1", "bankStbN idle", bankStbN, 8'hFF);
    runAccess(16'h1234, 0, 0, 0, 0, 0);
    chk("R1", "default length", mLen, 17);
    chk("R1", "default chip select low", mStbLow, 17);
    chk("R1", "default pin", mStbMask, 8'h01);
  endtask

  task automatic tWaits;
    for (int e = 0; e < 4; e++) begin
      writeCfg(3'd2, 8'(e << 6));
      runAccess(16'h4000, 0, 0, 0, 0, 0);
      chk("R3", "length", mLen, 2 + expWaits(e));
      chk("R3", "done position", mDone, 2 + expWaits(e));
      chk("R3", "done count", mDoneCnt, 1);
      chk("R4", "ioRdN first", mRdFirst, 2);
      chk("R4", "ioRdN low", mRdLow, 1 + expWaits(e));
      chk("R4", "ioWrN quiet on read", mWrLow, 0);
      chk("R2", "pin bank2", mStbMask, 8'h04);
    end
  endtask

  task automatic tDecode;
    for (int n = 0; n < 8; n++) begin
      writeCfg(3'(n), 8'hC0);
      runAccess({3'(n), 13'h1ABC}, 0, 1, 0, 0, 0);
      chk("R2", "pin for bank", mStbMask, 1 << n);
      chk("R3", "one-wait length", mLen, 3);
      chk("R4", "ioWrN low", mWrLow, 2);
      chk("R4", "ioRdN quiet on write", mRdLow, 0);
    end
  endtask

  task automatic tTypes;
    // type 01: read only
    writeCfg(3'd3, 8'hC8);
    runAccess(16'h6000, 0, 0, 0, 0, 0);
    chk("R7", "rd type on read", mStbLow, 2);
    chk("R7", "rd type first", mStbFirst, 2);
    runAccess(16'h6000, 0, 1, 0, 0, 0);
    chk("R7", "rd type on write", mStbLow, 0);
    // type 10: write only
    writeCfg(3'd3, 8'hD0);
    runAccess(16'h6000, 0, 0, 0, 0, 0);
    chk("R7", "wr type on read", mStbLow, 0);
    runAccess(16'h6000, 0, 1, 0, 0, 0);
    chk("R7", "wr type on write", mStbLow, 2);
    chk("R7", "wr type first", mStbFirst, 2);
    // type 11: both
    writeCfg(3'd3, 8'hD8);
    runAccess(16'h6000, 0, 0, 0, 0, 0);
    chk("R7", "rw type on read", mStbLow, 2);
    runAccess(16'h6000, 0, 1, 0, 0, 0);
    chk("R7", "rw type on write", mStbLow, 2);
    // type 00: chip select from first clock
    writeCfg(3'd3, 8'hC0);
    runAccess(16'h6000, 0, 1, 0, 0, 0);
    chk("R7", "cs type low", mStbLow, 3);
    chk("R7", "cs type first", mStbFirst, 1);
  endtask

  task automatic tEnable;
    writeCfg(3'd4, 8'h80);
    portDir = 8'hEF; portFunc = 8'hFF;
    runAccess(16'h8000, 0, 0, 0, 0, 0);
    chk("R8", "dir off pin", mStbLow, 0);
    chk("R5", "dir off length", mLen, 5);
    chk("R5", "dir off ioRdN", mRdLow, 4);
    portDir = 8'hFF; portFunc = 8'hEF;
    runAccess(16'h8000, 0, 1, 0, 0, 0);
    chk("R8", "func off pin", mStbLow, 0);
    chk("R5", "func off length", mLen, 5);
    portFunc = 8'hFF;
    runAccess(16'h8000, 0, 0, 0, 0, 0);
    chk("R8", "both on pin", mStbLow, 5);
    chk("R8", "both on mask", mStbMask, 8'h10);
  endtask

  task automatic tInhibit;
    writeCfg(3'd5, 8'hE0);
    runAccess(16'hA100, 0, 1, 0, 0, 0);
    chk("R6", "inhibit ioWrN", mWrLow, 0);
    chk("R6", "inhibit pin", mStbLow, 0);
    chk("R6", "inhibit length", mLen, 3);
    runAccess(16'hA100, 0, 0, 0, 0, 0);
    chk("R6", "inhibit read ioRdN", mRdLow, 2);
    chk("R6", "inhibit read pin", mStbLow, 3);
  endtask

  task automatic tInternal;
    runAccess(16'h6000, 1, 0, 0, 0, 0);
    chk("R9", "internal read length", mLen, 2);
    chk("R9", "internal done", mDone, 2);
    chk("R9", "internal ioRdN", mRdLow, 0);
    chk("R9", "internal pin", mStbLow, 0);
    runAccess(16'h0000, 1, 1, 0, 0, 0);
    chk("R9", "internal write length", mLen, 2);
    chk("R9", "internal ioWrN", mWrLow, 0);
  endtask

  task automatic tLateCfg;
    writeCfg(3'd1, 8'h80);
    runAccess(16'h2000, 0, 0, 2, 3'd1, 8'hC0);
    chk("R10", "current access keeps old waits", mLen, 5);
    runAccess(16'h2000, 0, 0, 0, 0, 0);
    chk("R10", "next access uses new waits", mLen, 3);
  endtask

  task automatic tBusyReq;
    writeCfg(3'd6, 8'h40);
    runAccess(16'hC000, 0, 1, 1, 0, 0);
    chk("R11", "length with extra request", mLen, 9);
    chk("R11", "single done", mDoneCnt, 1);
    chk("R11", "idle after access", busy, 0);
    @(negedge clk);
    chk("R11", "no restarted access", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tReset();
    tWaits();
    tDecode();
    tTypes();
    tEnable();
    tInhibit();
    tInternal();
    tLateCfg();
    tBusyReq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule